// File: doc/BRIEF.md
# Test-Access-Port Instruction Register with Status Capture

This block holds the instruction of a boundary-scan test access port. It sits behind a TAP state machine, which is not part of the block. That state machine supplies one strobe for each of the Test-Logic-Reset, Capture-IR, Shift-IR and Update-IR states, all timed to the test clock.

During an instruction scan, the register first captures a six-bit word. Its two low bits are a fixed marker, and its four upper bits carry live configuration status from the device. The captured word then shifts out on the serial output, least significant bit first, while the new instruction shifts in from the serial input. When the scan is updated, the shifted word becomes the parallel instruction that the decoder downstream acts on.

The status inputs describe the device. Two report the configuration: whether it has finished, and whether it is still initialising. The other two report the in-system programming engine: whether it is enabled, and whether its run has completed.

Top module: `jtag_ir_status`

## Requirements
- R1: On a Capture-IR cycle, bit 0 of the shift register loads 1 and bit 1 loads 0.
- R2: On a Capture-IR cycle, bit 2 loads the programming-complete status (`st_prog_fin`) and bit 3 loads the programming-enabled status (`st_prog_en`).
- R3: On a Capture-IR cycle, bit 4 loads the initialisation status (`st_init_ok`) and bit 5 loads the configuration-done status (`st_cfg_done`).
- R4: On each rising `tck` edge in Shift-IR, the register moves one place toward bit 0 and `tdi` enters bit 5. The captured word therefore leaves bit 0 first, and the first `tdi` bit appears at `tdo` after six shifts. Status changes after the capture do not alter the shifted word.
- R5: `tdo` is updated on the falling edge of `tck`. During Shift-IR it equals bit 0 of the shift register, and in any other state it is 0.
- R6: The parallel instruction `instr` changes only on Update-IR or a reset. It holds its value through capture and shift.
- R7: The synchronous reset `rst` and the Test-Logic-Reset strobe each set `instr` to the identification opcode `RESET_OP`, which is 6'b001001 by default.
- R8: On an Update-IR cycle, `instr` takes the value held in the shift register.
- R9: When Test-Logic-Reset and Update-IR are asserted in the same cycle, the reset wins and `instr` becomes `RESET_OP`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tap_reset | input | 1 | TAP is in Test-Logic-Reset |
| tap_capture | input | 1 | TAP is in Capture-IR |
| tap_shift | input | 1 | TAP is in Shift-IR |
| tap_update | input | 1 | TAP is in Update-IR |
| tdi | input | 1 | Serial test data in |
| st_cfg_done | input | 1 | Configuration-done status |
| st_init_ok | input | 1 | Initialisation status |
| st_prog_en | input | 1 | Programming-engine-enabled status |
| st_prog_fin | input | 1 | Programming-complete status |
| tdo | output | 1 | Serial test data out, updated on the falling edge |
| instr | output | IR_W | Current parallel instruction |

## Verification
The bench captures several status patterns and reads each captured word back bit by bit. A design with a status bit in the wrong position, or with the two fixed bits swapped, shows the wrong value at one particular shift count.

Status is changed in the middle of a shift. A design that reloaded the status at that point would show the new value instead of the captured one.

A shift is paused and then resumed, and it also runs past six bits. A design that drove a stale `tdo` outside Shift-IR, or that fed `tdi` into the wrong end of the register, would be caught by these runs. The bench also checks that `instr` holds through capture and shift. It asserts Update-IR together with Test-Logic-Reset, and a design that gave the update priority would load the scanned word instead of `RESET_OP`.

// File: rtl/jir_pkg.sv
package jir_pkg;
  localparam int IR_W = 6;
  localparam logic [1:0] CAP_FIXED = 2'b01;
  localparam logic [5:0] IDCODE_OP = 6'b001001;

  typedef struct packed {
    logic cfg_done;
    logic init_ok;
    logic prog_en;
    logic prog_fin;
  } jir_status_t;
endpackage

// File: rtl/jir_capture_pat.sv
module jir_capture_pat
  import jir_pkg::*;
#(
  parameter int IR_W = jir_pkg::IR_W
) (
  input  jir_status_t       status,
  output logic [IR_W-1:0]   pattern
);
  always_comb begin
    pattern      = '0;
    pattern[1:0] = CAP_FIXED;
    pattern[2]   = status.prog_fin;
    pattern[3]   = status.prog_en;
    pattern[4]   = status.init_ok;
    pattern[5]   = status.cfg_done;
  end
endmodule

// File: rtl/jir_shifter.sv
module jir_shifter #(
  parameter int IR_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            shift,
  input  logic            din,
  input  logic [IR_W-1:0] pattern,
  output logic [IR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= pattern;
    else if (shift) q <= {din, q[IR_W-1:1]};
  end
endmodule

// File: rtl/jir_update_reg.sv
module jir_update_reg #(
  parameter int              IR_W     = 6,
  parameter logic [IR_W-1:0] RESET_OP = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tap_reset,
  input  logic            update,
  input  logic [IR_W-1:0] d,
  output logic [IR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || tap_reset) q <= RESET_OP;
    else if (update)      q <= d;
  end
endmodule

// File: rtl/jir_tdo_stage.sv
module jir_tdo_stage (
  input  logic clk,
  input  logic rst,
  input  logic shift,
  input  logic bit_in,
  output logic tdo
);
  always_ff @(negedge clk) begin
    if (rst) tdo <= 1'b0;
    else     tdo <= shift ? bit_in : 1'b0;
  end
endmodule

// File: rtl/jtag_ir_status.sv
module jtag_ir_status
  import jir_pkg::*;
#(
  parameter int              IR_W     = jir_pkg::IR_W,
  parameter logic [IR_W-1:0] RESET_OP = IR_W'(jir_pkg::IDCODE_OP)
) (
  input  logic            tck,
  input  logic            rst,
  input  logic            tap_reset,
  input  logic            tap_capture,
  input  logic            tap_shift,
  input  logic            tap_update,
  input  logic            tdi,
  input  logic            st_cfg_done,
  input  logic            st_init_ok,
  input  logic            st_prog_en,
  input  logic            st_prog_fin,
  output logic            tdo,
  output logic [IR_W-1:0] instr
);
  jir_status_t     status;
  logic [IR_W-1:0] cap_word;
  logic [IR_W-1:0] shift_q;

  assign status = '{cfg_done: st_cfg_done, init_ok: st_init_ok,
                    prog_en: st_prog_en, prog_fin: st_prog_fin};

  jir_capture_pat #(.IR_W(IR_W)) u_cap (
    .status (status),
    .pattern(cap_word)
  );

  jir_shifter #(.IR_W(IR_W)) u_shift (
    .clk    (tck),
    .rst    (rst),
    .load   (tap_capture),
    .shift  (tap_shift),
    .din    (tdi),
    .pattern(cap_word),
    .q      (shift_q)
  );

  jir_update_reg #(.IR_W(IR_W), .RESET_OP(RESET_OP)) u_upd (
    .clk      (tck),
    .rst      (rst),
    .tap_reset(tap_reset),
    .update   (tap_update),
    .d        (shift_q),
    .q        (instr)
  );

  jir_tdo_stage u_tdo (
    .clk   (tck),
    .rst   (rst),
    .shift (tap_shift),
    .bit_in(shift_q[0]),
    .tdo   (tdo)
  );
endmodule

// File: rtl/jir_checker.sv
module jir_checker #(
  parameter int              IR_W     = 6,
  parameter logic [IR_W-1:0] RESET_OP = '0
) (
  input logic            tck,
  input logic            rst,
  input logic            tap_reset,
  input logic            tap_capture,
  input logic            tap_shift,
  input logic            tap_update,
  input logic            tdi,
  input logic            st_cfg_done,
  input logic            st_init_ok,
  input logic            st_prog_en,
  input logic            st_prog_fin,
  input logic            tdo,
  input logic [IR_W-1:0] instr,
  input logic [IR_W-1:0] sr
);
  // R1 R2 R3: captured word layout
  a_r1_r3_capture: assert property (@(posedge tck) disable iff (rst)
    tap_capture |=> sr[5:0] == {$past(st_cfg_done), $past(st_init_ok),
                                $past(st_prog_en), $past(st_prog_fin), 2'b01});

  // R4: shift direction and entry point
  a_r4_shift: assert property (@(posedge tck) disable iff (rst)
    (tap_shift && !tap_capture) |=> (sr[IR_W-1] == $past(tdi)) &&
                                    (sr[IR_W-2:0] == $past(sr[IR_W-1:1])));

  // R5: tdo follows bit 0 in Shift-IR, quiet otherwise
  a_r5_tdo_shift: assert property (@(posedge tck) disable iff (rst)
    tap_shift |-> tdo == sr[0]);
  a_r5_tdo_idle: assert property (@(posedge tck) disable iff (rst)
    !tap_shift |-> !tdo);

  // R6: instruction holds without update or reset
  a_r6_hold: assert property (@(posedge tck) disable iff (rst)
    (!tap_update && !tap_reset) |=> $stable(instr));

  // R7 R9: Test-Logic-Reset dominates
  a_r7_reset_op: assert property (@(posedge tck) disable iff (rst)
    tap_reset |=> instr == RESET_OP);

  // R8: update transfers the shift register
  a_r8_update: assert property (@(posedge tck) disable iff (rst)
    (tap_update && !tap_reset) |=> instr == $past(sr));
endmodule

bind jtag_ir_status jir_checker #(.IR_W(IR_W), .RESET_OP(RESET_OP)) u_chk (
  .tck(tck), .rst(rst), .tap_reset(tap_reset), .tap_capture(tap_capture),
  .tap_shift(tap_shift), .tap_update(tap_update), .tdi(tdi),
  .st_cfg_done(st_cfg_done), .st_init_ok(st_init_ok),
  .st_prog_en(st_prog_en), .st_prog_fin(st_prog_fin),
  .tdo(tdo), .instr(instr), .sr(shift_q)
);

// File: tb/jtag_ir_status_test.sv
module jtag_ir_status_test;
  localparam logic [5:0] ID_OP = 6'b001001;

  // {cfg_done, init_ok, prog_en, prog_fin, new instruction}
  localparam logic [9:0] VEC [6] = '{
    10'b0000_111111, 10'b1111_000000, 10'b1010_101010,
    10'b0101_010101, 10'b1000_001001, 10'b0001_110010
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tap_reset = 0, tap_capture = 0, tap_shift = 0, tap_update = 0, tdi = 0;
  logic [3:0] st = 4'b0000;
  logic tdo;
  logic [5:0] instr;
  int n_chk = 0;
  int n_fail = 0;
  logic [5:0] exp_instr;

  always #10 clk = ~clk;

  jtag_ir_status uut (
    .tck(clk), .rst(rst), .tap_reset(tap_reset), .tap_capture(tap_capture),
    .tap_shift(tap_shift), .tap_update(tap_update), .tdi(tdi),
    .st_cfg_done(st[3]), .st_init_ok(st[2]), .st_prog_en(st[1]),
    .st_prog_fin(st[0]), .tdo(tdo), .instr(instr)
  );

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // drive just after a rising edge, return just before the next one
  task automatic cyc(input logic cap, input logic sh, input logic up,
                     input logic tr, input logic d);
    @(posedge clk); #2;
    tap_capture = cap; tap_shift = sh; tap_update = up; tap_reset = tr; tdi = d;
    @(negedge clk); #5;
  endtask

  task automatic scan(input logic [3:0] s, input logic [5:0] nv);
    logic [5:0] cap;
    cap = {s, 2'b01};
    st = s;
    cyc(1, 0, 0, 0, 0);
    chk("R5 tdo low in capture", {5'b0, tdo}, 6'b0);
    for (int i = 0; i < 6; i++) begin
      cyc(0, 1, 0, 0, nv[i]);
      if (i == 0) st = ~s; // status change after capture must not show
      chk(i < 2 ? "R1 R4 tdo bit" : (i < 4 ? "R2 R4 tdo bit" : "R3 R4 tdo bit"),
          {5'b0, tdo}, {5'b0, cap[i]});
      chk("R6 instr held in shift", instr, exp_instr);
    end
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0);
    exp_instr = nv;
    chk("R8 instr after update", instr, exp_instr);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk); #5;
    chk("R7 instr after rst", instr, ID_OP);
    chk("R5 tdo after rst", {5'b0, tdo}, 6'b0);
    exp_instr = ID_OP;

    for (int v = 0; v < 6; v++) scan(VEC[v][9:6], VEC[v][5:0]);

    // R7: Test-Logic-Reset restores the identification opcode
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0);
    exp_instr = ID_OP;
    chk("R7 tap reset", instr, exp_instr);

    // R4 R5: pause mid-shift, resume, overrun past six bits
    st = 4'b1100;
    cyc(1, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 1);
    chk("R1 R4 first bit", {5'b0, tdo}, 6'd1);
    cyc(0, 1, 0, 0, 0);
    chk("R1 R4 second bit", {5'b0, tdo}, 6'd0);
    cyc(0, 0, 0, 0, 0);
    chk("R5 tdo low on pause", {5'b0, tdo}, 6'd0);
    cyc(0, 1, 0, 0, 1);
    chk("R2 R4 resumed bit", {5'b0, tdo}, 6'd0);
    cyc(0, 1, 0, 0, 1);
    cyc(0, 1, 0, 0, 0);
    chk("R3 R4 bit4", {5'b0, tdo}, 6'd1);
    cyc(0, 1, 0, 0, 0);
    chk("R3 R4 bit5", {5'b0, tdo}, 6'd1);
    // shifted-in sequence was 1,0,1,1,0,0 ; now it emerges
    cyc(0, 1, 0, 0, 0);
    chk("R4 first tdi out", {5'b0, tdo}, 6'd1);
    cyc(0, 1, 0, 0, 0);
    chk("R4 second tdi out", {5'b0, tdo}, 6'd0);
    cyc(0, 1, 0, 0, 0);
    chk("R4 third tdi out", {5'b0, tdo}, 6'd1);
    chk("R6 instr held", instr, exp_instr);

    // R9: update and Test-Logic-Reset together
    st = 4'b1111;
    cyc(1, 0, 0, 0, 0);
    for (int i = 0; i < 6; i++) cyc(0, 1, 0, 0, 1'b1);
    cyc(0, 0, 1, 1, 0);
    cyc(0, 0, 0, 0, 0);
    chk("R9 reset beats update", instr, ID_OP);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule